// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Phase Strobes

This block takes a fast input clock and produces a clock at one third of its frequency whose high and low times are equal, each lasting three input half-periods. An odd ratio cannot give an even split from rising edges alone, so the block uses both edges of the input clock. A three-phase counter advances on every rising edge. A second register captures the counter phase on every falling edge. Each output is the OR or AND of exactly one rising-edge flop and one falling-edge flop. Only one of those two flops changes at any input edge, so the outputs cannot glitch.

The block also produces two active-low strobes, each exactly one input half-period wide. The lead strobe marks the input low phase just before the divided clock rises. The trail strobe marks the last input high phase before the divided clock falls. For example, a 30 MHz input gives a 10 MHz output. The 50/50 split is exact only when the input clock itself has a 50% duty cycle, because nothing in the block corrects the input. A parameter selects how the phase counter is encoded. Both encodings produce identical outputs.

Top module: `div3_clk_strobe_gen`

## Requirements
- R1: While `rst` is high (sampled on rising edges of `clk_in`, with one full input period allowed to settle), `clk_div3` is 0 and both strobes are 1.
- R2: `clk_div3` repeats with a period of exactly three input periods, which is six input half-periods.
- R3: Number the half-periods from the first rising edge of `clk_in` after reset release as h = 0 to 5, repeating. `clk_div3` is 1 in h0, h1 and h2 and 0 in h3, h4 and h5.
- R4: `clk_div3` rises only on a rising edge of `clk_in`. It falls only on a falling edge of `clk_in`, one and a half input periods after the rise.
- R5: `lead_strobe_n` is 0 only in h5, the input low phase just before `clk_div3` rises, and is 1 at all other times.
- R6: `trail_strobe_n` is 0 only in h2, the final input high phase before `clk_div3` falls, and is 1 at all other times.
- R7: In every output period, each strobe is low for exactly one half-period, and the two strobes are never low at the same time.
- R8: With `RING_STYLE` set to `RING_BINARY` (a binary counter with a registered one-hot decode), every output is identical to the default `RING_ONEHOT` ring, half-period by half-period.
- R9: If reset is applied in the middle of an output period, the pattern restarts so that the first rising edge of `clk_in` after release begins h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| clk_div3 | output | 1 | Input clock divided by three, with equal high and low times |
| lead_strobe_n | output | 1 | Active-low strobe in the half-period before `clk_div3` rises |
| trail_strobe_n | output | 1 | Active-low strobe in the half-period before `clk_div3` falls |

## Verification
The assertions check on every input edge that the phase counter rotates in order and that the falling-edge capture tracks it. At each edge they also compare the divided clock and both strobes with the value the current phase calls for, separately in the input high phase and the input low phase, and they confirm the strobes are never low together.

Only the bench's scenarios can show that the six-step pattern is anchored to the first rising edge after reset release. The bench also shows that the period and the strobe widths hold across many output periods, that a reset in the middle of a high phase restarts the pattern cleanly, and that the two counter encodings give the same outputs.

// File: rtl/div3_pkg.sv
package div3_pkg;

   // Number of input periods in one output period (the divide ratio).
   localparam int unsigned PHASES = 3;

   // Width of the binary phase counter.
   localparam int unsigned CNT_W  = $clog2(PHASES);

   // Index of the phase that drives each output.
   localparam int unsigned PH_LEAD  = 0;
   localparam int unsigned PH_CLK   = 1;
   localparam int unsigned PH_TRAIL = 2;

   typedef logic [PHASES-1:0] phase_t;

   typedef enum logic [0:0] {
      RING_ONEHOT = 1'b0,
      RING_BINARY = 1'b1
   } ring_style_e;

endpackage

// File: rtl/div3_phase_ring.sv
module div3_phase_ring
   import div3_pkg::*;
#(
   parameter ring_style_e STYLE = RING_ONEHOT
) (
   input  logic   clk,
   input  logic   rst,
   output phase_t phase
);

   localparam phase_t PH_RESET = phase_t'(1);

   generate
      if (STYLE == RING_ONEHOT) begin : g_onehot
         phase_t ring_q;

         always_ff @(posedge clk) begin
            if (rst) ring_q <= PH_RESET;
            else     ring_q <= {ring_q[PHASES-2:0], ring_q[PHASES-1]};
         end

         assign phase = ring_q;
      end else begin : g_binary
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] cnt_nx;
         phase_t           dec_q;

         always_comb begin
            if (cnt_q == CNT_W'(PHASES-1)) cnt_nx = '0;
            else                           cnt_nx = cnt_q + 1'b1;
         end

         // The decode is registered so each output bit comes straight from a flop.
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               dec_q <= PH_RESET;
            end else begin
               cnt_q <= cnt_nx;
               dec_q <= PH_RESET << cnt_nx;
            end
         end

         assign phase = dec_q;
      end
   endgenerate

endmodule

// File: rtl/div3_fall_capture.sv
module div3_fall_capture #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   // Captures on the falling edge, so q follows d half an input period later.
   always_ff @(negedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/div3_out_merge.sv
module div3_out_merge
   import div3_pkg::*;
(
   input  phase_t rise_ph,
   input  phase_t fall_ph,
   output logic   clk_div,
   output logic   lead_n,
   output logic   trail_n
);

   // Each output combines one rising-edge flop with one falling-edge flop.
   // Only one of the two changes at any input edge, so no output can glitch.
   assign clk_div = rise_ph[PH_CLK] | fall_ph[PH_CLK];
   assign lead_n  = ~(rise_ph[PH_LEAD] & fall_ph[PH_LEAD]);
   assign trail_n = ~rise_ph[PH_TRAIL] | fall_ph[PH_TRAIL];

endmodule

// File: rtl/div3_clk_strobe_gen.sv
module div3_clk_strobe_gen
   import div3_pkg::*;
#(
   parameter ring_style_e RING_STYLE = RING_ONEHOT
) (
   input  logic clk_in,
   input  logic rst,
   output logic clk_div3,
   output logic lead_strobe_n,
   output logic trail_strobe_n
);

   generate
      if (PHASES != 3) begin : g_bad_ratio
         $error("div3_clk_strobe_gen: output mapping assumes a phase count of three");
      end
      if (PH_LEAD >= PHASES || PH_CLK >= PHASES || PH_TRAIL >= PHASES) begin : g_bad_index
         $error("div3_clk_strobe_gen: a phase index is out of range");
      end
   endgenerate

   phase_t phase_rise;
   phase_t phase_fall;

   div3_phase_ring #(.STYLE(RING_STYLE)) u_ring (
      .clk   (clk_in),
      .rst   (rst),
      .phase (phase_rise)
   );

   div3_fall_capture #(.W(PHASES)) u_fall (
      .clk (clk_in),
      .rst (rst),
      .d   (phase_rise),
      .q   (phase_fall)
   );

   div3_out_merge u_merge (
      .rise_ph (phase_rise),
      .fall_ph (phase_fall),
      .clk_div (clk_div3),
      .lead_n  (lead_strobe_n),
      .trail_n (trail_strobe_n)
   );

endmodule

// File: rtl/div3_clk_strobe_chk.sv
module div3_clk_strobe_chk
   import div3_pkg::*;
(
   input logic   clk,
   input logic   rst,
   input phase_t ph,
   input phase_t q,
   input logic   clk_out,
   input logic   lead_n,
   input logic   trail_n
);

   // Set once a complete phase-1 step has been seen since the last reset.
   logic seen_q;
   always_ff @(posedge clk) begin
      if (rst)                seen_q <= 1'b0;
      else if (ph[PH_CLK])    seen_q <= 1'b1;
   end

   // R2
   ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(ph) == 1);

   // R2
   ring_advance_chk: assert property (@(posedge clk) disable iff (rst)
      ph[PH_LEAD] |=> ph[PH_CLK]);

   // R2
   ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ph[PH_TRAIL] |=> ph[PH_LEAD]);

   // R4
   fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> (q == ph));

   // R3
   div_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
      clk_out == ph[PH_CLK]);

   // R3
   div_high_phase_chk: assert property (@(negedge clk) disable iff (rst)
      clk_out == (ph[PH_CLK] | ph[PH_TRAIL]));

   // R5
   lead_pos_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> (lead_n == !ph[PH_LEAD]));

   // R5
   lead_quiet_neg_chk: assert property (@(negedge clk) disable iff (rst)
      lead_n);

   // R6
   trail_neg_chk: assert property (@(negedge clk) disable iff (rst)
      trail_n == !ph[PH_TRAIL]);

   // R6
   trail_quiet_pos_chk: assert property (@(posedge clk) disable iff (rst)
      trail_n);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      lead_n || trail_n);

endmodule

bind div3_clk_strobe_gen div3_clk_strobe_chk u_chk (
   .clk     (clk_in),
   .rst     (rst),
   .ph      (phase_rise),
   .q       (phase_fall),
   .clk_out (clk_div3),
   .lead_n  (lead_strobe_n),
   .trail_n (trail_strobe_n)
);

// File: tb/div3_clk_strobe_gen_bench.sv
`timescale 1ns/1ps
module div3_clk_strobe_gen_bench;
   import div3_pkg::*;

   localparam int CLK_PERIOD = 34;
   localparam int QTR        = CLK_PERIOD / 4;
   localparam int NHALF      = 62;

   logic clk = 1'b0;
   logic rst = 1'b1;

   logic div_a, lead_a, trail_a;
   logic div_b, lead_b, trail_b;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   div3_clk_strobe_gen #(.RING_STYLE(RING_ONEHOT)) u_div3_clk_strobe_gen (
      .clk_in(clk), .rst(rst), .clk_div3(div_a),
      .lead_strobe_n(lead_a), .trail_strobe_n(trail_a));

   div3_clk_strobe_gen #(.RING_STYLE(RING_BINARY)) u_div3_clk_strobe_gen_bin (
      .clk_in(clk), .rst(rst), .clk_div3(div_b),
      .lead_strobe_n(lead_b), .trail_strobe_n(trail_b));

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_reset_vals(input string req);
      check_bit(req, "clk_div3 in reset",       div_a,   1'b0);
      check_bit(req, "lead_strobe_n in reset",  lead_a,  1'b1);
      check_bit(req, "trail_strobe_n in reset", trail_a, 1'b1);
      check_bit("R8", "binary clk_div3 in reset", div_b,  1'b0);
      check_bit("R8", "binary lead in reset",     lead_b, 1'b1);
      check_bit("R8", "binary trail in reset",    trail_b,1'b1);
   endtask

   // Runs the reference pattern for NHALF half-periods, starting on the next rising edge.
   task automatic run_pattern(input string start_req);
      int rises[$];
      int last_rise = -100;
      logic prev_div = 1'b0;
      int lead_cnt = 0, trail_cnt = 0, high_cnt = 0;
      for (int k = 0; k < NHALF; k++) begin
         int h;
         logic e_div, e_lead, e_trail;
         if (k % 2 == 0) @(posedge clk); else @(negedge clk);
         #(QTR);
         h       = k % 6;
         e_div   = (h < 3);
         e_lead  = (h != 5);
         e_trail = (h != 2);
         if (k == 0) check_bit(start_req, "first rising edge starts high phase", div_a, 1'b1);
         check_bit("R3", "clk_div3 step",      div_a,   e_div);
         check_bit("R5", "lead_strobe_n step", lead_a,  e_lead);
         check_bit("R6", "trail_strobe_n step",trail_a, e_trail);
         check_bit("R8", "binary clk_div3",    div_b,   div_a);
         check_bit("R8", "binary lead",        lead_b,  lead_a);
         check_bit("R8", "binary trail",       trail_b, trail_a);
         if (!lead_a)  lead_cnt++;
         if (!trail_a) trail_cnt++;
         if (div_a)    high_cnt++;
         if (!lead_a && !trail_a) check_bit("R7", "strobes both low", 1'b1, 1'b0);
         if (div_a && !prev_div) begin
            check_bit("R4", "rise on rising edge", (k % 2 == 0), 1'b1);
            if (rises.size() > 0) check_bit("R2", "period is six half-periods", (k - rises[$] == 6), 1'b1);
            rises.push_back(k);
            last_rise = k;
         end
         if (!div_a && prev_div) begin
            check_bit("R4", "fall on falling edge", (k % 2 == 1), 1'b1);
            check_bit("R4", "fall 1.5 periods after rise", (k - last_rise == 3), 1'b1);
         end
         prev_div = div_a;
         if (h == 5) begin
            check_bit("R7", "lead low exactly once",  (lead_cnt == 1),  1'b1);
            check_bit("R7", "trail low exactly once", (trail_cnt == 1), 1'b1);
            check_bit("R3", "three high half-periods", (high_cnt == 3), 1'b1);
            lead_cnt = 0; trail_cnt = 0; high_cnt = 0;
         end
      end
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #(QTR);
      check_reset_vals("R1");
      @(posedge clk); #(QTR);
      check_reset_vals("R1");

      // Release just after a falling edge; the next rising edge is h0.
      @(negedge clk); #2;
      rst = 1'b0;
      #(QTR);
      check_reset_vals("R1");
      run_pattern("R3");

      // The pattern ended in h1, where clk_div3 is high: reset mid-period.
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk); #(QTR);
      check_reset_vals("R9");
      @(posedge clk); #(QTR);
      check_reset_vals("R9");
      @(negedge clk); #2;
      rst = 1'b0;
      run_pattern("R9");

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule